// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits between instruction fetch and the base 32-bit decoder of an RV32IM core that also runs the integer part of the compressed extension. Each cycle it looks at one fetched 32-bit word. When the low halfword is a 16-bit compressed instruction, the block rebuilds it as the equivalent full-width encoding. Otherwise the word goes through unchanged. The result goes to a decoder that knows nothing about compressed code.

The unit is purely combinational. It reports whether the word was compressed, so fetch can advance the program counter by 2 or by 4. It also flags any 16-bit pattern outside the supported integer subset as illegal. The stack-pointer forms, the compact three-bit register fields (which select x8 to x15) and the implicit x0, x1 and x2 operands are all rebuilt here.

Top module: `rvc_expander`

## Requirements
- R1: When bits [1:0] of the fetched word are 2'b11, the output word equals the input word, and both the compressed flag and the illegal flag are 0.
- R2: The compressed flag is 1 exactly when bits [1:0] are not 2'b11. For a compressed word, bits [31:16] of the input have no effect on any output. Every legal expansion has bits [1:0] equal to 2'b11.
- R3: The immediate and shift forms expand as follows:
  - C.ADDI to ADDI rd,rd,imm.
  - C.LI to ADDI rd,x0,imm.
  - C.ANDI to ANDI on rs1'.
  - C.LUI to LUI rd,imm, with the 6-bit immediate sign-extended into bits [31:12].
  - C.SLLI, C.SRLI and C.SRAI to the shift with the same register as source and destination, and a 5-bit shift amount.
  - The 6-bit immediates of C.ADDI, C.LI and C.ANDI are sign-extended.
- R4: The register forms expand as follows:
  - C.ADD to ADD rd,rd,rs2.
  - C.MV to ADD rd,x0,rs2.
  - C.SUB, C.XOR, C.OR and C.AND to the matching R-type operation with rd'=rs1'.
  - A compact register field value n means register x(8+n).
- R5: The stack-pointer forms use x2 as the base register:
  - C.ADDI4SPN expands to ADDI rd',x2 with a zero-extended offset scaled by 4.
  - C.ADDI16SP expands to ADDI x2,x2 with a sign-extended offset scaled by 16.
  - C.LWSP and C.SWSP expand to LW or SW with a zero-extended offset scaled by 4 (8 bits wide).
- R6: C.LW and C.SW expand to LW and SW on compact registers, with a zero-extended 7-bit offset scaled by 4.
- R7: The control-transfer forms expand as follows:
  - C.J expands to JAL x0 and C.JAL to JAL x1, each with a sign-extended 12-bit offset.
  - C.JR expands to JALR x0,0(rs1) and C.JALR to JALR x1,0(rs1).
  - C.BEQZ and C.BNEZ expand to BEQ or BNE rs1',x0 with a sign-extended 9-bit offset.
- R8: The illegal flag is set, and the output word is all zeros, for each of the following:
  - the all-zero halfword;
  - C.ADDI4SPN, C.ADDI16SP or C.LUI with a zero immediate;
  - any shift with bit 12 set;
  - C.LWSP with rd=x0;
  - C.JR with rs1=x0;
  - the breakpoint pattern 0x9002;
  - the 64-bit arithmetic forms (bit 12 set in the register-operation group);
  - any quadrant/funct3 pair outside the supported set.
- R9: The outputs follow the input within the same cycle, with no clock and no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetchWord | input | 32 | Fetched word; the low halfword is examined first |
| expandedInsn | output | 32 | Full-width instruction for the base decoder (zero when illegal) |
| isCompressed | output | 1 | Low halfword was a 16-bit instruction |
| isIllegal | output | 1 | Compressed pattern outside the supported integer subset |

## Verification
The bench compares each expansion with a hand-assembled golden encoding. It aims at the places where an expander usually goes wrong:
- **Scattered immediates.** The negative jump and branch offsets and the scaled stack offsets would give a wrong target or frame address if one bit were swapped or sign extension were missing.
- **Reserved patterns.** The zero-immediate C.ADDI4SPN, C.ADDI16SP and C.LUI, the shifts with bit 12 set, C.LWSP to x0, C.JR with x0 and the breakpoint pattern would otherwise reach the decoder as a plausible instruction instead of raising the illegal flag.
- **C.MV versus C.ADD.** A mixup would silently add the old destination value.
- **Upper halfword.** Driving garbage into bits [31:16] of a compressed word would expose any leak of that data into the expansion.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int ILEN = 32;
  localparam int CLEN = 16;
  localparam int RLEN = 5;

  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;

  localparam logic [RLEN-1:0] REG_ZERO = 5'd0;
  localparam logic [RLEN-1:0] REG_LINK = 5'd1;
  localparam logic [RLEN-1:0] REG_SP   = 5'd2;

  typedef enum logic [4:0] {
    X_PASS, X_BAD, X_SPWIDE, X_LDW, X_STW, X_ADDI, X_CALL, X_LDI,
    X_SPADJ, X_UPPER, X_SHRL, X_SHRA, X_ANDI, X_SUB, X_XOR, X_OR,
    X_AND, X_JUMP, X_BRZ, X_BRNZ, X_SHL, X_LDSP, X_JREG, X_MOVE,
    X_CALLREG, X_ADD, X_STSP
  } expandOp_e;

  typedef struct packed {
    expandOp_e op;
    logic      compressed;
    logic      illegal;
  } ctrlStrobe_t;

  function automatic logic [ILEN-1:0] encI(logic [11:0] imm, logic [4:0] rs1,
                                           logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [ILEN-1:0] encS(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], OPC_STORE};
  endfunction

  function automatic logic [ILEN-1:0] encB(logic [12:0] imm, logic [4:0] rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], REG_ZERO, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [ILEN-1:0] encJ(logic [20:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction

  function automatic logic [ILEN-1:0] encR(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                           logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, OPC_OP};
  endfunction
endpackage

// File: rtl/rvc_ctrl.sv
module rvc_ctrl
  import rvc_pkg::*;
(
  input  logic [CLEN-1:0] half,
  output ctrlStrobe_t     strobe
);
  logic [1:0] quad;
  logic [2:0] fn3;
  logic       bit12;
  logic [4:0] rdFld;
  logic [4:0] rs2Fld;

  assign quad   = half[1:0];
  assign fn3    = half[15:13];
  assign bit12  = half[12];
  assign rdFld  = half[11:7];
  assign rs2Fld = half[6:2];

  expandOp_e opSel;

  always_comb begin
    opSel = X_BAD;
    unique case (quad)
      2'b00: begin
        case (fn3)
          3'b000:  opSel = (half[12:5] == 8'd0) ? X_BAD : X_SPWIDE;
          3'b010:  opSel = X_LDW;
          3'b110:  opSel = X_STW;
          default: opSel = X_BAD;
        endcase
      end
      2'b01: begin
        case (fn3)
          3'b000: opSel = X_ADDI;
          3'b001: opSel = X_CALL;
          3'b010: opSel = X_LDI;
          3'b011: begin
            if ({bit12, rs2Fld} == 6'd0) opSel = X_BAD;
            else if (rdFld == REG_SP)    opSel = X_SPADJ;
            else                         opSel = X_UPPER;
          end
          3'b100: begin
            case (half[11:10])
              2'b00: opSel = bit12 ? X_BAD : X_SHRL;
              2'b01: opSel = bit12 ? X_BAD : X_SHRA;
              2'b10: opSel = X_ANDI;
              default: begin
                if (bit12) opSel = X_BAD;
                else begin
                  case (half[6:5])
                    2'b00:   opSel = X_SUB;
                    2'b01:   opSel = X_XOR;
                    2'b10:   opSel = X_OR;
                    default: opSel = X_AND;
                  endcase
                end
              end
            endcase
          end
          3'b101:  opSel = X_JUMP;
          3'b110:  opSel = X_BRZ;
          default: opSel = X_BRNZ;
        endcase
      end
      2'b10: begin
        case (fn3)
          3'b000: opSel = bit12 ? X_BAD : X_SHL;
          3'b010: opSel = (rdFld == REG_ZERO) ? X_BAD : X_LDSP;
          3'b100: begin
            if (rs2Fld != REG_ZERO)      opSel = bit12 ? X_ADD : X_MOVE;
            else if (rdFld == REG_ZERO)  opSel = X_BAD;
            else                         opSel = bit12 ? X_CALLREG : X_JREG;
          end
          3'b110:  opSel = X_STSP;
          default: opSel = X_BAD;
        endcase
      end
      default: opSel = X_PASS;
    endcase
  end

  assign strobe.op         = opSel;
  assign strobe.compressed = (quad != 2'b11);
  assign strobe.illegal    = (opSel == X_BAD);
endmodule

// File: rtl/rvc_datapath.sv
module rvc_datapath
  import rvc_pkg::*;
(
  input  logic [ILEN-1:0] word,
  input  ctrlStrobe_t     strobe,
  output logic [ILEN-1:0] expanded
);
  logic [CLEN-1:0] c;
  assign c = word[CLEN-1:0];

  logic [4:0] rdFull, rs2Full, rdShort, rs1Short;
  assign rdFull   = c[11:7];
  assign rs2Full  = c[6:2];
  assign rdShort  = {2'b01, c[4:2]};
  assign rs1Short = {2'b01, c[9:7]};

  logic [11:0] immSmall, immWide4, immWord, immLdSp, immStSp, immSp16, immShl, immShr, immSha;
  logic [19:0] immUpper;
  logic [20:0] immJump;
  logic [12:0] immBranch;

  assign immSmall  = {{6{c[12]}}, c[12], c[6:2]};
  assign immWide4  = {2'b00, c[10:7], c[12:11], c[5], c[6], 2'b00};
  assign immWord   = {5'd0, c[5], c[12:10], c[6], 2'b00};
  assign immLdSp   = {4'd0, c[3:2], c[12], c[6:4], 2'b00};
  assign immStSp   = {4'd0, c[8:7], c[12:9], 2'b00};
  assign immSp16   = {{3{c[12]}}, c[4:3], c[5], c[2], c[6], 4'd0};
  assign immShl    = {7'd0, c[6:2]};
  assign immShr    = {7'd0, c[6:2]};
  assign immSha    = {7'b0100000, c[6:2]};
  assign immUpper  = {{14{c[12]}}, c[12], c[6:2]};
  assign immJump   = {{10{c[12]}}, c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
  assign immBranch = {{5{c[12]}}, c[6:5], c[2], c[11:10], c[4:3], 1'b0};

  always_comb begin
    expanded = '0;
    unique case (strobe.op)
      X_PASS:    expanded = word;
      X_SPWIDE:  expanded = encI(immWide4, REG_SP, 3'b000, rdShort, OPC_OPIMM);
      X_LDW:     expanded = encI(immWord, rs1Short, 3'b010, rdShort, OPC_LOAD);
      X_STW:     expanded = encS(immWord, rdShort, rs1Short);
      X_ADDI:    expanded = encI(immSmall, rdFull, 3'b000, rdFull, OPC_OPIMM);
      X_CALL:    expanded = encJ(immJump, REG_LINK);
      X_LDI:     expanded = encI(immSmall, REG_ZERO, 3'b000, rdFull, OPC_OPIMM);
      X_SPADJ:   expanded = encI(immSp16, REG_SP, 3'b000, REG_SP, OPC_OPIMM);
      X_UPPER:   expanded = {immUpper, rdFull, OPC_LUI};
      X_SHRL:    expanded = encI(immShr, rs1Short, 3'b101, rs1Short, OPC_OPIMM);
      X_SHRA:    expanded = encI(immSha, rs1Short, 3'b101, rs1Short, OPC_OPIMM);
      X_ANDI:    expanded = encI(immSmall, rs1Short, 3'b111, rs1Short, OPC_OPIMM);
      X_SUB:     expanded = encR(7'b0100000, rdShort, rs1Short, 3'b000, rs1Short);
      X_XOR:     expanded = encR(7'd0, rdShort, rs1Short, 3'b100, rs1Short);
      X_OR:      expanded = encR(7'd0, rdShort, rs1Short, 3'b110, rs1Short);
      X_AND:     expanded = encR(7'd0, rdShort, rs1Short, 3'b111, rs1Short);
      X_JUMP:    expanded = encJ(immJump, REG_ZERO);
      X_BRZ:     expanded = encB(immBranch, rs1Short, 3'b000);
      X_BRNZ:    expanded = encB(immBranch, rs1Short, 3'b001);
      X_SHL:     expanded = encI(immShl, rdFull, 3'b001, rdFull, OPC_OPIMM);
      X_LDSP:    expanded = encI(immLdSp, REG_SP, 3'b010, rdFull, OPC_LOAD);
      X_JREG:    expanded = encI(12'd0, rdFull, 3'b000, REG_ZERO, OPC_JALR);
      X_MOVE:    expanded = encR(7'd0, rs2Full, REG_ZERO, 3'b000, rdFull);
      X_CALLREG: expanded = encI(12'd0, rdFull, 3'b000, REG_LINK, OPC_JALR);
      X_ADD:     expanded = encR(7'd0, rs2Full, rdFull, 3'b000, rdFull);
      X_STSP:    expanded = encS(immStSp, rs2Full, REG_SP);
      default:   expanded = '0;
    endcase
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_pkg::*;
(
  input  logic [31:0] fetchWord,
  output logic [31:0] expandedInsn,
  output logic        isCompressed,
  output logic        isIllegal
);
  ctrlStrobe_t ctrlBus;

  rvc_ctrl u_ctrl (
    .half   (fetchWord[CLEN-1:0]),
    .strobe (ctrlBus)
  );

  rvc_datapath u_dpath (
    .word     (fetchWord),
    .strobe   (ctrlBus),
    .expanded (expandedInsn)
  );

  assign isCompressed = ctrlBus.compressed;
  assign isIllegal    = ctrlBus.illegal;
endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk (
  input logic [31:0] fetchWord,
  input logic [31:0] expandedInsn,
  input logic        isCompressed,
  input logic        isIllegal
);
  always_comb begin
    if (fetchWord[1:0] == 2'b11) begin
      AST_PASS_THROUGH: assert (expandedInsn == fetchWord && !isCompressed && !isIllegal) // R1
        else $error("pass-through broken");
    end
    AST_COMP_FLAG: assert (isCompressed == (fetchWord[1:0] != 2'b11)) // R2
      else $error("compressed flag wrong");
    if (isCompressed && !isIllegal) begin
      AST_EXPANDED_WIDE: assert (expandedInsn[1:0] == 2'b11) // R2
        else $error("expansion not full width");
    end
    if (isIllegal) begin
      AST_ILLEGAL_ZERO: assert (expandedInsn == 32'd0) // R8
        else $error("illegal output not zero");
    end
    if (fetchWord[15:0] == 16'd0) begin
      AST_ZERO_HALF_BAD: assert (isIllegal) // R8
        else $error("zero halfword accepted");
    end
    if (isCompressed && !isIllegal &&
        (expandedInsn[6:0] == 7'b1101111 || expandedInsn[6:0] == 7'b1100111)) begin
      AST_LINK_RD: assert (expandedInsn[11:7] == 5'd0 || expandedInsn[11:7] == 5'd1) // R7
        else $error("jump link register wrong");
    end
    if (fetchWord[1:0] == 2'b00 && fetchWord[15:13] == 3'b010) begin
      AST_COMPACT_REG: assert (expandedInsn[11:10] == 2'b01 && expandedInsn[19:18] == 2'b01) // R6
        else $error("compact register mapping wrong");
    end
  end
endmodule

bind rvc_expander rvc_expander_chk u_chk (
  .fetchWord    (fetchWord),
  .expandedInsn (expandedInsn),
  .isCompressed (isCompressed),
  .isIllegal    (isIllegal)
);

// File: tb/rvc_expander_tb.sv
module rvc_expander_tb;
  logic        clk = 1'b0;
  logic [31:0] fetchWord;
  logic [31:0] expandedInsn;
  logic        isCompressed;
  logic        isIllegal;
  int          checkCount = 0;
  int          failCount  = 0;
  bit          finished   = 1'b0;

  always #10 clk = ~clk;

  rvc_expander u_dut (
    .fetchWord    (fetchWord),
    .expandedInsn (expandedInsn),
    .isCompressed (isCompressed),
    .isIllegal    (isIllegal)
  );

  localparam int NVEC = 40;
  // {input, expected word, compressed, illegal, requirement number}
  localparam logic [69:0] VECS [NVEC] = '{
    {32'hFFF00593, 32'hFFF00593, 1'b0, 1'b0, 4'd1},  // R1 full-width addi
    {32'h00000013, 32'h00000013, 1'b0, 1'b0, 4'd1},  // R1 nop
    {32'h00004201, 32'h00000213, 1'b1, 1'b0, 4'd3},  // R3 li x4,0
    {32'h00004405, 32'h00100413, 1'b1, 1'b0, 4'd3},  // R3 li x8,1
    {32'h000072FD, 32'hFFFFF2B7, 1'b1, 1'b0, 4'd3},  // R3 lui negative
    {32'h0000840D, 32'h40345413, 1'b1, 1'b0, 4'd3},  // R3 srai
    {32'h000083FD, 32'h01F7D793, 1'b1, 1'b0, 4'd3},  // R3 srli 31
    {32'h000098F9, 32'hFFE4F493, 1'b1, 1'b0, 4'd3},  // R3 andi -2
    {32'h000010FD, 32'hFFF08093, 1'b1, 1'b0, 4'd3},  // R3 addi -1
    {32'h00000292, 32'h00429293, 1'b1, 1'b0, 4'd3},  // R3 slli
    {32'h00009192, 32'h004181B3, 1'b1, 1'b0, 4'd4},  // R4 add
    {32'h00008C05, 32'h40940433, 1'b1, 1'b0, 4'd4},  // R4 sub
    {32'h00008C25, 32'h00944433, 1'b1, 1'b0, 4'd4},  // R4 xor
    {32'h00008C45, 32'h00946433, 1'b1, 1'b0, 4'd4},  // R4 or
    {32'h00008D6D, 32'h00B57533, 1'b1, 1'b0, 4'd4},  // R4 and
    {32'h0000852E, 32'h00B00533, 1'b1, 1'b0, 4'd4},  // R4 mv
    {32'h00000040, 32'h00410413, 1'b1, 1'b0, 4'd5},  // R5 addi4spn
    {32'h0000717D, 32'hFF010113, 1'b1, 1'b0, 4'd5},  // R5 addi16sp -16
    {32'h00004432, 32'h00C12403, 1'b1, 1'b0, 4'd5},  // R5 lwsp
    {32'h0000C00E, 32'h00312023, 1'b1, 1'b0, 4'd5},  // R5 swsp 0
    {32'h0000C222, 32'h00812223, 1'b1, 1'b0, 4'd5},  // R5 swsp 4
    {32'h00004144, 32'h00452483, 1'b1, 1'b0, 4'd6},  // R6 lw
    {32'h0000C124, 32'h04952023, 1'b1, 1'b0, 4'd6},  // R6 sw offset 64
    {32'h0000BFFD, 32'hFFFFF06F, 1'b1, 1'b0, 4'd7},  // R7 j -2
    {32'h00002011, 32'h004000EF, 1'b1, 1'b0, 4'd7},  // R7 jal +4
    {32'h0000C401, 32'h00040463, 1'b1, 1'b0, 4'd7},  // R7 beqz +8
    {32'h0000FCF5, 32'hFE049EE3, 1'b1, 1'b0, 4'd7},  // R7 bnez -4
    {32'h00008082, 32'h00008067, 1'b1, 1'b0, 4'd7},  // R7 jr
    {32'h00009282, 32'h000280E7, 1'b1, 1'b0, 4'd7},  // R7 jalr
    {32'h00000000, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8 zero halfword
    {32'h00006101, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8 addi16sp zero
    {32'h00006281, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8 lui zero
    {32'h00009001, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8 srli bit12
    {32'h00001292, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8 slli bit12
    {32'h00004032, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8 lwsp x0
    {32'h00008002, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8 jr x0
    {32'h00009002, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8 breakpoint
    {32'h00009C05, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8 64-bit sub form
    {32'h00008000, 32'h00000000, 1'b1, 1'b1, 4'd8},  // R8 reserved quadrant 0
    {32'h00002002, 32'h00000000, 1'b1, 1'b1, 4'd8}   // R8 float form
  };

  task automatic checkOut(input string req, input logic [31:0] expW,
                          input logic expC, input logic expI);
    checkCount++;
    if (expandedInsn !== expW || isCompressed !== expC || isIllegal !== expI) begin
      failCount++;
      $display("FAIL %s in=%h actual=%h/%b/%b expected=%h/%b/%b", req, fetchWord,
               expandedInsn, isCompressed, isIllegal, expW, expC, expI);
    end
  endtask

  initial begin
    fetchWord = 32'h00000013;
    @(negedge clk);
    #2 checkOut("R1 idle", 32'h00000013, 1'b0, 1'b0);
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      fetchWord = VECS[i][69:38];
      #2 checkOut($sformatf("R%0d vector %0d", VECS[i][3:0], i),
                  VECS[i][37:6], VECS[i][5], VECS[i][4]);
    end
    // R2: upper halfword has no effect on a compressed expansion
    @(negedge clk);
    fetchWord = 32'hABCD9192;
    #2 checkOut("R2 upper garbage add", 32'h004181B3, 1'b1, 1'b0);
    @(negedge clk);
    fetchWord = 32'hFFFF0040;
    #2 checkOut("R2 upper ones addi4spn", 32'h00410413, 1'b1, 1'b0);
    @(negedge clk);
    fetchWord = 32'h12340000;
    #2 checkOut("R2 upper data zero half", 32'h00000000, 1'b1, 1'b1);
    // R9: output changes with no clock edge between stimulus and sample
    @(posedge clk);
    #1 fetchWord = 32'h0000C401;
    #1 checkOut("R9 same-cycle branch", 32'h00040463, 1'b1, 1'b0);
    #1 fetchWord = 32'hFFF00593;
    #1 checkOut("R9 same-cycle pass", 32'hFFF00593, 1'b0, 1'b0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule